// File: doc/BRIEF.md
# External Memory Access Gap Sequencer

The block sits between the request queue of a static memory controller and the engine that drives the external bus. Before each new external access it decides how many idle cycles to insert, based on how the next access differs from the previous one. Three reasons are considered: a change of chip select, a change of transfer direction, and a pending configuration reload. They are merged by fixed rules. A chip-select change absorbs a pending reload. A direction change always adds its own cycle after the others.

A reload is armed in two ways: by a write strobe to any chip select's mode register, or by the slow-clock-mode level changing in either direction. Strobes to the timing registers alone never arm it. The queue holds its request on `req_valid`, `req_cs` and `req_write` until `start` is seen high at a clock edge. Each idle cycle is reported on `gap_kind`.

Top module: `smc_gap_seq`

## Requirements
- R1: After reset `start` and `gap_kind` are 0. The first access after reset starts in the same cycle it is presented with the bus free, with no idle cycle. While `start` is high, `gap_kind` is 0.
- R2: When the chip select differs from the previous access's, exactly one idle cycle with `gap_kind`=1 precedes `start`.
- R3: A mode-register write strobe arms a reload, whichever chip select the register belongs to. The next access to the same chip select as the previous one gets exactly one idle cycle with `gap_kind`=2 before `start`.
- R4: A timing-register strobe without a mode-register strobe arms nothing, so the next unchanged access starts with no idle cycle.
- R5: A pending reload whose next access changes chip select produces only the single `gap_kind`=1 cycle, and the reload is then cleared: a following same-chip-select, same-direction access starts at once.
- R6: A direction change between consecutive accesses inserts one idle cycle with `gap_kind`=3. It comes after any `gap_kind`=1 or 2 cycle and immediately before `start`.
- R7: A change of `slow_mode`, rising or falling, arms a reload exactly as a mode-register write does.
- R8: A mode-register strobe during a `gap_kind`=2 cycle re-arms the reload, so the following same-chip-select access again gets a `gap_kind`=2 cycle.
- R9: An access with the same chip select and direction and no pending reload starts in the cycle it is presented.
- R10: While `bus_busy` is high in the waiting state, no access is started and no idle cycle is inserted.
- R11: A mode-register strobe in the same cycle as a start decision stays pending for the following access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is presented and held until started |
| req_cs | input | CS_W | Chip select of the presented request |
| req_write | input | 1 | 1 = write, 0 = read |
| bus_busy | input | 1 | The bus engine is still finishing the previous transfer |
| cfg_mode_wr | input | 1 | Strobe: some mode register was written |
| cfg_timing_wr | input | 1 | Strobe: some timing register was written |
| slow_mode | input | 1 | Slow clock mode level |
| start | output | 1 | Grant: the presented access starts this cycle |
| gap_kind | output | 2 | Current idle cycle: 0 none, 1 chip select, 2 reload, 3 direction |

## Verification
The two functions that can land in the same cycle are consuming a reload idle cycle and arming a new reload. To provoke this, the bench pulses the mode-register strobe exactly in the cycle where `gap_kind` reads 2. The result is judged at the ports: the scoreboard expects a second reload cycle before the next same-chip-select access. A second overlap is also covered: a reload is pending when the chip select changes. The scoreboard expects a lone chip-select cycle, and then no idle cycle at all on the next access.

// File: rtl/smc_gap_seq.sv
module smc_gap_seq #(
  parameter int CS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [CS_W-1:0] req_cs,
  input  logic            req_write,
  input  logic            bus_busy,
  input  logic            cfg_mode_wr,
  input  logic            cfg_timing_wr,
  input  logic            slow_mode,
  output logic            start,
  output logic [1:0]      gap_kind
);
  localparam logic [1:0] K_NONE = 2'd0, K_CS = 2'd1, K_RLD = 2'd2, K_RW = 2'd3;

  typedef enum logic [1:0] {S_WAIT, S_GAP1, S_GAP2, S_GO} st_t;
  st_t st;

  logic            have_prev, prev_wr, pend, slow_q, rw_hold, g1_rld;
  logic [CS_W-1:0] prev_cs;

  wire arm      = cfg_mode_wr | (slow_mode ^ slow_q);
  wire look     = (st == S_WAIT) && req_valid && !bus_busy;
  wire cs_chg   = have_prev && (req_cs != prev_cs);
  wire rld_need = have_prev && pend && !cs_chg;
  wire dir_chg  = have_prev && (req_write != prev_wr);

  assign start    = (st == S_GO) || (look && !cs_chg && !rld_need && !dir_chg);
  assign gap_kind = (st == S_GAP1) ? (g1_rld ? K_RLD : K_CS) :
                    (st == S_GAP2) ? K_RW : K_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_WAIT;
      have_prev <= 1'b0;
      prev_wr   <= 1'b0;
      prev_cs   <= '0;
      pend      <= 1'b0;
      slow_q    <= 1'b0;
      rw_hold   <= 1'b0;
      g1_rld    <= 1'b0;
    end else begin
      slow_q <= slow_mode;
      case (st)
        S_WAIT:
          if (look) begin
            if (cs_chg || rld_need) begin
              st      <= S_GAP1;
              g1_rld  <= !cs_chg;
              rw_hold <= dir_chg;
            end else if (dir_chg) begin
              st <= S_GAP2;
            end
          end
        S_GAP1: st <= rw_hold ? S_GAP2 : S_GO;
        S_GAP2: st <= S_GO;
        default: st <= S_WAIT;
      endcase
      if (arm)
        pend <= 1'b1;
      else if (st == S_GAP1 || (look && !have_prev))
        pend <= 1'b0;
      if (start) begin
        have_prev <= 1'b1;
        prev_cs   <= req_cs;
        prev_wr   <= req_write;
      end
    end
  end

  p_start_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> gap_kind == K_NONE);
  p_cs_gap_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_kind == K_CS |=> (start || gap_kind == K_RW));
  p_rld_gap_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gap_kind == K_RLD |=> (start || gap_kind == K_RW));
  p_arm_on_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_wr |=> pend);
  p_timing_no_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && cfg_timing_wr && !cfg_mode_wr && slow_mode == slow_q) |=> !pend);
  p_rw_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    gap_kind == K_RW |=> start);
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && bus_busy) |-> (!start && gap_kind == K_NONE));
endmodule

// File: tb/smc_gap_seq_tb.sv
module smc_gap_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, bus_busy = 1'b0;
  logic cfg_mode_wr = 1'b0, cfg_timing_wr = 1'b0, slow_mode = 1'b0;
  logic [1:0] req_cs = '0;
  logic start;
  logic [1:0] gap_kind;

  int total = 0, bad = 0;
  int q_kind[$];
  string q_tag[$];
  int got, exp_k;
  string tg;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  smc_gap_seq #(.CS_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cs(req_cs),
    .req_write(req_write), .bus_busy(bus_busy), .cfg_mode_wr(cfg_mode_wr),
    .cfg_timing_wr(cfg_timing_wr), .slow_mode(slow_mode),
    .start(start), .gap_kind(gap_kind));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: event 4 = start, 1..3 = idle cycle kind
  always @(negedge clk) begin
    if (rst_n && !finished && (start || gap_kind != 2'd0)) begin
      got = start ? 4 : int'(gap_kind);
      if (q_kind.size() == 0) begin
        check(1'b0, "unexpected event", got, 0);
      end else begin
        exp_k = q_kind.pop_front();
        tg = q_tag.pop_front();
        check(got == exp_k, tg, got, exp_k);
      end
    end
  end

  task automatic push(input int k, input string tag);
    if (k != 0) begin
      q_kind.push_back(k);
      q_tag.push_back(tag);
    end
  endtask

  task automatic access(input logic [1:0] cs, input logic wr, input string tag,
                        input int k0, input int k1, input bit pulse_in_gap);
    push(k0, tag); push(k1, tag); push(4, tag);
    @(posedge clk); #1;
    req_cs = cs; req_write = wr; req_valid = 1'b1;
    if (pulse_in_gap) begin
      @(posedge clk); #1 cfg_mode_wr = 1'b1;
      @(posedge clk); #1 cfg_mode_wr = 1'b0;
    end
    @(negedge clk);
    while (!start) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic pulse_mode();
    @(posedge clk); #1 cfg_mode_wr = 1'b1;
    @(posedge clk); #1 cfg_mode_wr = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(start == 1'b0, "R1 reset start", int'(start), 0);
    check(gap_kind == 2'd0, "R1 reset kind", int'(gap_kind), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    access(2'd0, 1'b0, "R1 first access", 0, 0, 0);
    access(2'd0, 1'b0, "R9 same cs dir", 0, 0, 0);
    access(2'd1, 1'b0, "R2 cs change", 1, 0, 0);

    @(posedge clk); #1 cfg_timing_wr = 1'b1;
    @(posedge clk); #1 cfg_timing_wr = 1'b0;
    access(2'd1, 1'b0, "R4 timing only", 0, 0, 0);

    pulse_mode();
    access(2'd1, 1'b0, "R3 reload same cs", 2, 0, 0);

    pulse_mode();
    access(2'd2, 1'b0, "R5 reload absorbed", 1, 0, 0);
    access(2'd2, 1'b0, "R5 reload cleared", 0, 0, 0);

    access(2'd2, 1'b1, "R6 dir change", 3, 0, 0);
    access(2'd3, 1'b0, "R6 cs then dir", 1, 3, 0);
    pulse_mode();
    access(2'd3, 1'b1, "R6 reload then dir", 2, 3, 0);

    @(posedge clk); #1 slow_mode = 1'b1;
    access(2'd3, 1'b1, "R7 slow enter", 2, 0, 0);
    @(posedge clk); #1 slow_mode = 1'b0;
    access(2'd3, 1'b1, "R7 slow exit", 2, 0, 0);

    pulse_mode();
    access(2'd3, 1'b1, "R8 reload w/ rearm", 2, 0, 1);
    access(2'd3, 1'b1, "R8 rearmed reload", 2, 0, 0);

    // R11: mode strobe coincident with an immediate start decision
    push(4, "R11 coincident start");
    @(posedge clk); #1;
    req_cs = 2'd3; req_write = 1'b1; req_valid = 1'b1; cfg_mode_wr = 1'b1;
    @(posedge clk); #1 req_valid = 1'b0; cfg_mode_wr = 1'b0;
    access(2'd3, 1'b1, "R11 pending kept", 2, 0, 0);

    // R10: busy holds off the start
    push(4, "R10 busy release");
    @(posedge clk); #1;
    bus_busy = 1'b1; req_cs = 2'd3; req_write = 1'b1; req_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(start == 1'b0, "R10 no start while busy", int'(start), 0);
    end
    @(posedge clk); #1 bus_busy = 1'b0;
    @(negedge clk);
    while (!start) @(negedge clk);
    @(posedge clk); #1 req_valid = 1'b0;

    repeat (4) @(posedge clk);
    check(q_kind.size() == 0, "R1 all expected events seen", q_kind.size(), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    check(1'b0, "watchdog expired", 0, 1);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule